// File: doc/BRIEF.md
# Descriptor Chain Sequencer

The sequencer drives a single transfer channel through a linked list of segment descriptors that live in memory. Software loads the first segment straight into the channel registers through a word-write port while the channel is idle. Writing the control word with its enable bit set starts the first segment. The external transfer engine is told to begin each segment with a one-cycle start pulse, and it reports the end of the segment with a one-cycle done pulse.

When a segment finishes, the sequencer looks at its link register. A zero link ends the chain and the channel returns to idle. A non-zero link is treated as the address of the next descriptor, forced onto a 32-byte boundary. The sequencer reads that descriptor one word at a time over a simple read port, with one read outstanding at a time. It keeps the words in a shadow buffer and copies them into the channel registers together once the last word has arrived. It then starts the next segment. A descriptor whose link points back to an earlier one produces an endless, cyclic stream.

The link register is always visible, so software can work out how much of the chain is left. A segment-complete event pulses when the finished segment's control word asks for it. A force-close input stops the channel at once, including in the middle of a descriptor fetch.

Top module: `lldc_chain_seq`

## Requirements
- R1: After reset the channel is idle. The busy, start, event and read-request outputs are low, and every channel register reads zero.
- R2: While idle, a software write with index 8 (control) and bit 0 of the data set starts the channel. Busy is high and seg_start pulses for exactly one cycle, in the cycle after the write is sampled.
- R3: Software writes made while the channel is busy are ignored, and the channel registers keep their values.
- R4: When seg_done arrives and the current link is zero, the channel is idle in the next cycle and issues no descriptor reads.
- R5: When seg_done arrives and the link is non-zero, the sequencer issues nine reads. Read i (i = 0..8) goes to address (link with bits 4:0 cleared) + 4*i. Each request lasts one cycle, and only one read is outstanding at a time.
- R6: The channel registers do not change during a fetch. All of them take the fetched values in the same cycle as the ninth read's data arrives, and seg_start pulses in the following cycle.
- R7: A chain whose last link points back to an earlier descriptor keeps starting segments in the linked order without end.
- R8: One cycle after seg_done, seg_evt pulses if and only if bits 4 and 5 of the finished segment's control word are both 1.
- R9: chan_link always shows the link word of the segment that is loaded, including while that segment is running.
- R10: A force_close pulse makes the channel idle in the next cycle from any state. A fetch in progress is dropped, no further reads or starts follow, and the channel registers are left as they were. Read data that arrives late is ignored.
- R11: Descriptor word order, which is also the software write index: 0 source, 1 destination, 2 byte count, 3 zy count, 4 source step, 5 destination step, 6 reserved (never stored), 7 link, 8 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software register write strobe |
| sw_idx | input | 4 | Software register word index (descriptor order) |
| sw_wdata | input | 32 | Software register write data |
| force_close | input | 1 | Stop the channel immediately |
| seg_done | input | 1 | Engine reports end of current segment |
| seg_start | output | 1 | Engine may begin the loaded segment |
| seg_evt | output | 1 | Segment-complete event |
| busy | output | 1 | Channel active (running or fetching) |
| chan_src | output | 32 | Source address register |
| chan_dst | output | 32 | Destination address register |
| chan_xcnt | output | 32 | Byte count register |
| chan_zycnt | output | 32 | ZY count register |
| chan_sstep | output | 32 | Source ZY step register |
| chan_dstep | output | 32 | Destination ZY step register |
| chan_link | output | 32 | Link (next descriptor address) register |
| chan_ctrl | output | 32 | Control register |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions take some things about the inputs for granted. mem_rvalid comes only in answer to an outstanding request, and never in the same cycle as that request. seg_done is raised only while a segment is running. The one exception is late read data after a force close, which the sequencer must ignore. The bench's memory model answers each request a configurable one to six cycles later and holds at most one read in flight. Its engine model pulses seg_done only after it has seen seg_start, so the stimulus stays within these assumptions.

// File: rtl/lldc_pkg.sv
package lldc_pkg;

  // Descriptor word order; software write index uses the same numbering.
  localparam int unsigned DESC_WORDS = 9;
  localparam int unsigned W_SRC   = 0;
  localparam int unsigned W_DST   = 1;
  localparam int unsigned W_XCNT  = 2;
  localparam int unsigned W_ZYCNT = 3;
  localparam int unsigned W_SSTEP = 4;
  localparam int unsigned W_DSTEP = 5;
  localparam int unsigned W_RSVD  = 6;
  localparam int unsigned W_LINK  = 7;
  localparam int unsigned W_CTRL  = 8;

  // Stored fields: every descriptor word except the reserved one.
  localparam int unsigned N_FIELDS = DESC_WORDS - 1;
  localparam int unsigned IDX_W    = $clog2(DESC_WORDS);

  // Field slot numbers inside the register file.
  localparam int unsigned F_SRC   = 0;
  localparam int unsigned F_DST   = 1;
  localparam int unsigned F_XCNT  = 2;
  localparam int unsigned F_ZYCNT = 3;
  localparam int unsigned F_SSTEP = 4;
  localparam int unsigned F_DSTEP = 5;
  localparam int unsigned F_LINK  = 6;
  localparam int unsigned F_CTRL  = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/lldc_fetch.sv
module lldc_fetch
  import lldc_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ALIGN_BITS = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [DW-ALIGN_BITS-1:0] link_hi,
  input  logic                     adv,
  output logic [DW-1:0]            mem_addr,
  output logic [IDX_W-1:0]         word_idx
);

  localparam int unsigned BASE_W = DW - ALIGN_BITS;

  logic [BASE_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    base_d = base_q;
    idx_d  = idx_q;
    if (load) begin
      base_d = link_hi;
      idx_d  = '0;
    end else if (adv) begin
      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      base_q <= base_d;
      idx_q  <= idx_d;
    end
  end

  // Descriptor spans more than one alignment unit, so add rather than OR.
  assign mem_addr = {base_q, {ALIGN_BITS{1'b0}}} + DW'({idx_q, 2'b00});
  assign word_idx = idx_q;

endmodule

// File: rtl/lldc_regfile.sv
module lldc_regfile
  import lldc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sw_ld,
  input  logic [IDX_W-1:0]             sw_idx,
  input  logic [DW-1:0]                sw_wdata,
  input  logic                         fetch_wr,
  input  logic [IDX_W-1:0]             fetch_idx,
  input  logic [DW-1:0]                rdata,
  input  logic                         commit,
  output logic [N_FIELDS-1:0][DW-1:0]  fields_o
);

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    localparam int unsigned WIDX = (f < W_RSVD) ? f : f + 1;

    logic [DW-1:0] q, d;

    if (f == N_FIELDS - 1) begin : g_last
      // Final word arrives with the commit itself; no shadow needed.
      always_comb begin
        d = q;
        if (commit) begin
          d = rdata;
        end else if (sw_ld && (sw_idx == IDX_W'(WIDX))) begin
          d = sw_wdata;
        end
      end
    end else begin : g_body
      logic [DW-1:0] sh_q, sh_d;

      always_comb begin
        sh_d = sh_q;
        if (fetch_wr && (fetch_idx == IDX_W'(WIDX))) begin
          sh_d = rdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q <= sh_d;
        end
      end

      always_comb begin
        d = q;
        if (commit) begin
          d = sh_q;
        end else if (sw_ld && (sw_idx == IDX_W'(WIDX))) begin
          d = sw_wdata;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        q <= d;
      end
    end

    assign fields_o[f] = q;
  end

endmodule

// File: rtl/lldc_ctrl.sv
module lldc_ctrl
  import lldc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             sw_en_bit,
  input  logic             force_close,
  input  logic             seg_done,
  input  logic             link_zero,
  input  logic             irq_en,
  input  logic             mem_rvalid,
  input  logic [IDX_W-1:0] word_idx,
  output logic             busy,
  output logic             mem_req,
  output logic             seg_start,
  output logic             seg_evt,
  output logic             sw_ld,
  output logic             fetch_ld,
  output logic             fetch_wr,
  output logic             commit
);

  seq_state_e state_q, state_d;
  logic       start_d, evt_d;

  always_comb begin
    state_d  = state_q;
    start_d  = 1'b0;
    evt_d    = 1'b0;
    fetch_ld = 1'b0;
    fetch_wr = 1'b0;
    commit   = 1'b0;
    sw_ld    = sw_we && (state_q == ST_IDLE) && !force_close;
    case (state_q)
      ST_IDLE: begin
        if (sw_ld && (sw_idx == IDX_W'(W_CTRL)) && sw_en_bit) begin
          state_d = ST_RUN;
          start_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (seg_done) begin
          evt_d = irq_en;
          if (link_zero) begin
            state_d = ST_IDLE;
          end else begin
            state_d  = ST_REQ;
            fetch_ld = 1'b1;
          end
        end
      end
      ST_REQ: begin
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rvalid) begin
          fetch_wr = 1'b1;
          if (word_idx == IDX_W'(DESC_WORDS - 1)) begin
            commit  = 1'b1;
            state_d = ST_RUN;
            start_d = 1'b1;
          end else begin
            state_d = ST_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (force_close) begin
      state_d  = ST_IDLE;
      start_d  = 1'b0;
      evt_d    = 1'b0;
      fetch_ld = 1'b0;
      fetch_wr = 1'b0;
      commit   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      seg_start <= 1'b0;
      seg_evt   <= 1'b0;
    end else begin
      state_q   <= state_d;
      seg_start <= start_d;
      seg_evt   <= evt_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign mem_req = (state_q == ST_REQ);

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_start |=> !seg_start); // R2
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R4
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R5
  AST_EVT_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_evt |-> $past(seg_done)); // R8
  AST_CLOSE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    force_close |=> !busy); // R10

endmodule

// File: rtl/lldc_chain_seq.sv
module lldc_chain_seq
  import lldc_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ALIGN_BITS = 5,
  parameter int unsigned EN_BIT     = 0,
  parameter int unsigned IRQ_LO     = 4,
  parameter int unsigned IRQ_HI     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [DW-1:0]    sw_wdata,
  input  logic             force_close,
  input  logic             seg_done,
  output logic             seg_start,
  output logic             seg_evt,
  output logic             busy,
  output logic [DW-1:0]    chan_src,
  output logic [DW-1:0]    chan_dst,
  output logic [DW-1:0]    chan_xcnt,
  output logic [DW-1:0]    chan_zycnt,
  output logic [DW-1:0]    chan_sstep,
  output logic [DW-1:0]    chan_dstep,
  output logic [DW-1:0]    chan_link,
  output logic [DW-1:0]    chan_ctrl,
  output logic             mem_req,
  output logic [DW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata
);

  logic [N_FIELDS-1:0][DW-1:0] fields;
  logic                        sw_ld, fetch_ld, fetch_wr, commit;
  logic [IDX_W-1:0]            word_idx;
  logic                        link_zero, irq_en;

  assign link_zero = (chan_link == '0);
  assign irq_en    = chan_ctrl[IRQ_HI] & chan_ctrl[IRQ_LO];

  lldc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_we),
    .sw_idx      (sw_idx),
    .sw_en_bit   (sw_wdata[EN_BIT]),
    .force_close (force_close),
    .seg_done    (seg_done),
    .link_zero   (link_zero),
    .irq_en      (irq_en),
    .mem_rvalid  (mem_rvalid),
    .word_idx    (word_idx),
    .busy        (busy),
    .mem_req     (mem_req),
    .seg_start   (seg_start),
    .seg_evt     (seg_evt),
    .sw_ld       (sw_ld),
    .fetch_ld    (fetch_ld),
    .fetch_wr    (fetch_wr),
    .commit      (commit)
  );

  lldc_fetch #(
    .DW         (DW),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fetch_ld),
    .link_hi  (chan_link[DW-1:ALIGN_BITS]),
    .adv      (fetch_wr),
    .mem_addr (mem_addr),
    .word_idx (word_idx)
  );

  lldc_regfile #(
    .DW (DW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_ld     (sw_ld),
    .sw_idx    (sw_idx),
    .sw_wdata  (sw_wdata),
    .fetch_wr  (fetch_wr),
    .fetch_idx (word_idx),
    .rdata     (mem_rdata),
    .commit    (commit),
    .fields_o  (fields)
  );

  assign chan_src   = fields[F_SRC];
  assign chan_dst   = fields[F_DST];
  assign chan_xcnt  = fields[F_XCNT];
  assign chan_zycnt = fields[F_ZYCNT];
  assign chan_sstep = fields[F_SSTEP];
  assign chan_dstep = fields[F_DSTEP];
  assign chan_link  = fields[F_LINK];
  assign chan_ctrl  = fields[F_CTRL];

  AST_LINK_HELD_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> $stable(chan_link)); // R6

endmodule

// File: tb/sim_lldc_chain_seq.sv
module sim_lldc_chain_seq;
  import lldc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk, rst_n;
  logic        sw_we, force_close, seg_done, mem_rvalid;
  logic [3:0]  sw_idx;
  logic [31:0] sw_wdata, mem_rdata;
  logic        seg_start, seg_evt, busy, mem_req;
  logic [31:0] chan_src, chan_dst, chan_xcnt, chan_zycnt, chan_sstep, chan_dstep;
  logic [31:0] chan_link, chan_ctrl, mem_addr;

  int          n_chk, n_fail, n_req, lat, fw, rcnt;
  logic [31:0] exp_base, raddr;
  logic [31:0] mem [0:255];

  lldc_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_idx(sw_idx), .sw_wdata(sw_wdata),
    .force_close(force_close), .seg_done(seg_done), .seg_start(seg_start),
    .seg_evt(seg_evt), .busy(busy), .chan_src(chan_src), .chan_dst(chan_dst),
    .chan_xcnt(chan_xcnt), .chan_zycnt(chan_zycnt), .chan_sstep(chan_sstep),
    .chan_dstep(chan_dstep), .chan_link(chan_link), .chan_ctrl(chan_ctrl),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int s, input int w);
    return 32'hC000_0000 | 32'(s << 12) | 32'(w << 4);
  endfunction

  task automatic set_desc(input int s, input logic [31:0] lnk, input logic [31:0] ctl);
    for (int w = 0; w < 9; w++)
      mem[s*16+w] = (w == 7) ? lnk : (w == 8) ? ctl : pat(s, w);
  endtask

  task automatic sw_write(input int idx, input logic [31:0] data);
    sw_idx   = 4'(idx);
    sw_wdata = data;
    sw_we    = 1'b1;
    @(negedge clk);
    sw_we    = 1'b0;
  endtask

  // Memory model: one read in flight, data after lat cycles; checks R5 addresses.
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rcnt > 0) begin
      rcnt--;
      if (rcnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[raddr[9:2]];
      end
    end else if (mem_req) begin
      n_req++;
      chk("R5 fetch address", mem_addr, exp_base + 32'(fw * 4));
      fw++;
      raddr = mem_addr;
      rcnt  = lat;
    end
  end

  task automatic check_regs(input string tag, input int s);
    chk({tag, " R11 src"},   chan_src,   mem[s*16+0]);
    chk({tag, " R11 dst"},   chan_dst,   mem[s*16+1]);
    chk({tag, " R11 xcnt"},  chan_xcnt,  mem[s*16+2]);
    chk({tag, " R11 zycnt"}, chan_zycnt, mem[s*16+3]);
    chk({tag, " R11 sstep"}, chan_sstep, mem[s*16+4]);
    chk({tag, " R11 dstep"}, chan_dstep, mem[s*16+5]);
    chk({tag, " R9 link"},   chan_link,  mem[s*16+7]);
    chk({tag, " R11 ctrl"},  chan_ctrl,  mem[s*16+8]);
  endtask

  // Load head through software, then service nseg segments as the engine.
  task automatic run_chain(input int head, input int nseg, input string tag);
    int          cur, t, n0;
    logic [31:0] lnk, ctl;
    cur = head;
    for (int w = 0; w < 9; w++) sw_write(w, mem[head*16+w]);
    for (int k = 0; k < nseg; k++) begin
      t = 0;
      while (!seg_start && t < 400) begin
        @(negedge clk);
        t++;
      end
      if (!seg_start) begin
        chk({tag, " R6 segment start seen"}, 32'd0, 32'd1);
        return;
      end
      if (k == 0) chk({tag, " R2 start one cycle after control write"}, 32'(t), 32'd0);
      else        chk({tag, " R5 nine words read"}, 32'(fw), 32'd9);
      check_regs({tag, " R6 R7"}, cur);
      chk({tag, " R2 busy"}, 32'(busy), 32'd1);
      repeat (2) @(negedge clk);
      lnk      = mem[cur*16+7];
      ctl      = mem[cur*16+8];
      exp_base = lnk & ~32'h1f;
      fw       = 0;
      seg_done = 1'b1;
      @(negedge clk);
      seg_done = 1'b0;
      chk({tag, " R8 segment event"}, 32'(seg_evt), 32'(ctl[5] & ctl[4]));
      if (lnk == 32'd0) begin
        chk({tag, " R4 idle after zero link"}, 32'(busy), 32'd0);
        n0 = n_req;
        repeat (20) @(negedge clk);
        chk({tag, " R4 no reads after zero link"}, 32'(n_req), 32'(n0));
        return;
      end
      cur = int'(lnk[9:6]);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n0, starts;
    n_chk = 0; n_fail = 0; n_req = 0; fw = 0; rcnt = 0; lat = 1;
    exp_base = '0; raddr = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rst_n = 1'b0; sw_we = 1'b0; sw_idx = '0; sw_wdata = '0;
    force_close = 1'b0; seg_done = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 seg_start", 32'(seg_start), 32'd0);
    chk("R1 seg_evt", 32'(seg_evt), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 src", chan_src, 32'd0);
    chk("R1 link", chan_link, 32'd0);
    chk("R1 ctrl", chan_ctrl, 32'd0);

    // Single segment, zero link.
    set_desc(0, 32'd0, 32'h31);
    run_chain(0, 1, "single");

    // Three-segment chain, misaligned links, latency and event-bit sweep.
    for (int p = 0; p < 2; p++) begin
      for (int l = 1; l <= 4; l++) begin
        lat = l;
        set_desc(1, 32'(3*64) | 32'h0C, (p == 0) ? 32'h31 : 32'h01);
        set_desc(3, 32'(2*64) | 32'h1F, (p == 0) ? 32'h11 : 32'h31);
        set_desc(2, 32'd0,              (p == 0) ? 32'h21 : 32'h31);
        run_chain(1, 3, "chain");
      end
    end

    // R3: write while busy is ignored.
    lat = 2;
    set_desc(5, 32'd0, 32'h01);
    for (int w = 0; w < 9; w++) sw_write(w, mem[5*16+w]);
    sw_write(0, 32'hDEAD_BEEF);
    chk("R3 src unchanged while busy", chan_src, pat(5, 0));
    seg_done = 1'b1;
    @(negedge clk);
    seg_done = 1'b0;
    chk("R3 R4 idle after segment", 32'(busy), 32'd0);

    // R7: cyclic chain 6 -> 7 -> 6, stopped by force close.
    set_desc(6, 32'(7*64), 32'h31);
    set_desc(7, 32'(6*64), 32'h31);
    run_chain(6, 5, "cyclic");
    force_close = 1'b1;
    @(negedge clk);
    force_close = 1'b0;
    chk("R7 R10 cyclic stopped", 32'(busy), 32'd0);
    repeat (20) @(negedge clk);

    // R10: force close in the middle of a fetch.
    lat = 6;
    set_desc(8, 32'(9*64), 32'h01);
    set_desc(9, 32'd0, 32'h01);
    run_chain(8, 1, "close");
    repeat (4) @(negedge clk);
    force_close = 1'b1;
    @(negedge clk);
    force_close = 1'b0;
    chk("R10 idle after close", 32'(busy), 32'd0);
    n0 = n_req;
    starts = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (seg_start) starts++;
    end
    chk("R10 no start after close", 32'(starts), 32'd0);
    chk("R10 no reads after close", 32'(n_req), 32'(n0));
    check_regs("R10 R6 regs kept", 8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule